// File: doc/BRIEF.md
# Real-Time Clock Alarm Match Unit

The unit holds five alarm bytes (seconds, minutes, hours, day of month, month). It compares them with the current time once after each once-per-second time update. Time counting is done elsewhere. The counter that does it gives a one-cycle strobe when an update has finished. At that strobe the unit checks each field. If every field agrees, the unit latches an alarm flag, sends a one-cycle alarm event to a companion unit, and can raise an interrupt request.

An alarm byte whose two most significant bits are both 1 is a wildcard. A valid BCD or binary time value never has that pattern, so the byte agrees with any current value. Wildcards turn the alarm into a periodic event. Real seconds and minutes with wildcard hours, day and month give an hourly alarm. Adding real hours gives a daily alarm. Five wildcards fire on every update. The flag stays set until software clears it. A match that occurs while the flag is set does not produce a second interrupt edge.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset the flag, the event and the interrupt outputs are 0 and all five alarm bytes are 0x00.
- R2: The comparison is made only in a cycle where `tick_done` is 1. A matching time with no strobe never sets the flag.
- R3: The flag is set only when all five fields match. A difference in any single field (seconds byte 0, minutes byte 1, hours byte 2, day byte 3, month byte 4 of `cur_time`) prevents it.
- R4: An alarm byte with bits 7:6 equal to 2'b11 matches any current value. Other values of bits 7:6 (such as 2'b10) are compared exactly.
- R5: The flag rises on the clock edge that samples a matching strobe. It stays 1 until an edge that samples `flag_clr` with no match.
- R6: `irq` rises with the flag only if `irq_en` is 1 at the matching edge. Setting `irq_en` later does not raise it.
- R7: A match while the flag is already set produces no new rising edge on `irq`.
- R8: `alarm_evt` is 1 for exactly the one cycle after each matching strobe, whether or not the flag was already set.
- R9: When `flag_clr` and a matching strobe meet at the same edge, the flag stays 1. The match counts as a new alarm for `irq`.
- R10: A write with `wr_sel` 0 to 4 loads `wr_data` into the seconds, minutes, hours, day or month alarm byte, and a strobe in the next cycle uses the new value. Writes with `wr_sel` 5 to 7 change nothing.
- R11: `irq` falls at the edge after `irq_en` goes to 0, and `alarm_flag` is unaffected. `irq` also falls when the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_time | input | 40 | Current time: byte 0 seconds up to byte 4 month |
| tick_done | input | 1 | One-cycle strobe: the time update has finished |
| wr_en | input | 1 | Alarm byte write strobe |
| wr_sel | input | 3 | Alarm byte index for the write |
| wr_data | input | 8 | Alarm byte write data |
| irq_en | input | 1 | Alarm interrupt enable |
| flag_clr | input | 1 | Clears the alarm flag (status read side effect) |
| alarm_flag | output | 1 | Latched alarm flag |
| alarm_evt | output | 1 | One-cycle alarm indication to the companion unit |
| irq | output | 1 | Alarm interrupt request, active high |

## Verification
The assertions assume that `cur_time` is steady while `tick_done` is high, and that `tick_done` is a single-cycle strobe from the time counter. They also assume that `flag_clr` stands for a read of the status register rather than a level held across many updates. The bench changes `cur_time` only in the same negative-edge slot that raises the strobe and drops it one cycle later. It asserts `flag_clr` for one cycle at a time. Writes to the alarm bytes never overlap a strobe except in the case that checks the next-cycle effect of a write.

// File: rtl/rtc_alarm_pkg.sv
// Shared constants for the real-time clock alarm match unit.
// Assumes the time fields are bytes and the wildcard lives in the top two bits.
package rtc_alarm_pkg;

    // Field indices; the order is the byte order of the time bus
    typedef enum logic [2:0] {
        FLD_SEC = 3'd0,
        FLD_MIN = 3'd1,
        FLD_HR  = 3'd2,
        FLD_DAY = 3'd3,
        FLD_MON = 3'd4
    } field_e;

    localparam int unsigned ALM_FIELDS  = 5;
    localparam int unsigned ALM_FIELD_W = 8;
    localparam int unsigned ALM_WILD_W  = 2;

endpackage

// File: rtl/rtc_alarm_regs.sv
// Alarm byte storage: one byte per time field, written one at a time.
// Assumes writes to an index at or above N_FIELDS are to be dropped.
module rtc_alarm_regs #(
    parameter int unsigned N_FIELDS = rtc_alarm_pkg::ALM_FIELDS,
    parameter int unsigned FIELD_W  = rtc_alarm_pkg::ALM_FIELD_W,
    parameter int unsigned SEL_W    = $clog2(N_FIELDS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [SEL_W-1:0]             wr_sel,
    input  logic [FIELD_W-1:0]           wr_data,
    output logic [N_FIELDS*FIELD_W-1:0]  alarm_flat
);

    localparam logic [FIELD_W-1:0] RESET_VAL = '0;

    for (genvar gi = 0; gi < N_FIELDS; gi++) begin : g_byte
        logic [FIELD_W-1:0] byte_q;
        logic               hit_sel;

        // Decode whether this byte is the write target
        always_comb begin
            hit_sel = wr_en && (wr_sel == SEL_W'(gi));
        end

        // Hold the alarm byte; load it on a targeted write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= RESET_VAL;
            end else if (hit_sel) begin
                byte_q <= wr_data;
            end
        end

        assign alarm_flat[gi*FIELD_W +: FIELD_W] = byte_q;
    end

endmodule

// File: rtl/rtc_alarm_cmp.sv
// Per-field comparison of alarm bytes against the current time.
// A byte whose top WILD_W bits are all ones matches any time value.
// Purely combinational; the caller qualifies the result with the update strobe.
module rtc_alarm_cmp #(
    parameter int unsigned N_FIELDS = rtc_alarm_pkg::ALM_FIELDS,
    parameter int unsigned FIELD_W  = rtc_alarm_pkg::ALM_FIELD_W,
    parameter int unsigned WILD_W   = rtc_alarm_pkg::ALM_WILD_W
) (
    input  logic [N_FIELDS*FIELD_W-1:0] alarm_flat,
    input  logic [N_FIELDS*FIELD_W-1:0] time_flat,
    output logic [N_FIELDS-1:0]         field_hit,
    output logic                        all_hit
);

    for (genvar gi = 0; gi < N_FIELDS; gi++) begin : g_fld
        logic [FIELD_W-1:0] alm_b;
        logic [FIELD_W-1:0] now_b;
        logic               wild;
        logic               equal;

        // Slice the two bytes and judge this field
        always_comb begin
            alm_b        = alarm_flat[gi*FIELD_W +: FIELD_W];
            now_b        = time_flat[gi*FIELD_W +: FIELD_W];
            wild         = &alm_b[FIELD_W-1 -: WILD_W];
            equal        = (alm_b == now_b);
            field_hit[gi] = wild | equal;
        end
    end

    // All fields must agree for an alarm
    always_comb begin
        all_hit = &field_hit;
    end

endmodule

// File: rtl/rtc_alarm_status.sv
// Alarm flag, companion event pulse and interrupt request.
// Assumes tick_done is a single-cycle strobe and all_hit is valid with it.
// A match wins over a clear at the same edge; irq rises only on a fresh alarm.
module rtc_alarm_status (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_done,
    input  logic all_hit,
    input  logic irq_en,
    input  logic flag_clr,
    output logic alarm_flag,
    output logic alarm_evt,
    output logic irq
);

    logic match_now;
    logic fresh;
    logic flag_q;
    logic evt_q;
    logic irq_q;

    // Qualify the comparison with the update strobe and detect a new alarm
    always_comb begin
        match_now = tick_done & all_hit;
        fresh     = match_now & (~flag_q | flag_clr);
    end

    // Latched flag: set by a match, cleared by a status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (match_now) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    // One-cycle indication per match to the companion unit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else begin
            evt_q <= match_now;
        end
    end

    // Interrupt request: raised on a fresh alarm when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (!irq_en) begin
            irq_q <= 1'b0;
        end else if (fresh) begin
            irq_q <= 1'b1;
        end else if (flag_clr) begin
            irq_q <= 1'b0;
        end
    end

    assign alarm_flag = flag_q;
    assign alarm_evt  = evt_q;
    assign irq        = irq_q;

endmodule

// File: rtl/rtc_alarm_match.sv
// Top of the alarm match unit: alarm byte storage, field comparators
// and status logic. Assumes cur_time is stable while tick_done is high.
module rtc_alarm_match #(
    parameter int unsigned N_FIELDS = rtc_alarm_pkg::ALM_FIELDS,
    parameter int unsigned FIELD_W  = rtc_alarm_pkg::ALM_FIELD_W,
    parameter int unsigned WILD_W   = rtc_alarm_pkg::ALM_WILD_W,
    parameter int unsigned SEL_W    = $clog2(N_FIELDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_FIELDS*FIELD_W-1:0] cur_time,
    input  logic                        tick_done,
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            wr_sel,
    input  logic [FIELD_W-1:0]          wr_data,
    input  logic                        irq_en,
    input  logic                        flag_clr,
    output logic                        alarm_flag,
    output logic                        alarm_evt,
    output logic                        irq
);

    logic [N_FIELDS*FIELD_W-1:0] alarm_flat;
    logic [N_FIELDS-1:0]         field_hit;
    logic                        all_hit;

    rtc_alarm_regs #(
        .N_FIELDS (N_FIELDS),
        .FIELD_W  (FIELD_W),
        .SEL_W    (SEL_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .alarm_flat (alarm_flat)
    );

    rtc_alarm_cmp #(
        .N_FIELDS (N_FIELDS),
        .FIELD_W  (FIELD_W),
        .WILD_W   (WILD_W)
    ) u_cmp (
        .alarm_flat (alarm_flat),
        .time_flat  (cur_time),
        .field_hit  (field_hit),
        .all_hit    (all_hit)
    );

    rtc_alarm_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_done  (tick_done),
        .all_hit    (all_hit),
        .irq_en     (irq_en),
        .flag_clr   (flag_clr),
        .alarm_flag (alarm_flag),
        .alarm_evt  (alarm_evt),
        .irq        (irq)
    );

endmodule

// File: rtl/rtc_alarm_match_chk.sv
// Protocol checker for rtc_alarm_match, bound to every instance.
// Assumes tick_done is a single-cycle strobe.
module rtc_alarm_match_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_done,
    input logic irq_en,
    input logic flag_clr,
    input logic alarm_flag,
    input logic alarm_evt,
    input logic irq
);

    // The flag can only rise at an edge that sampled the strobe
    assert_flag_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(tick_done));

    // The flag holds until a clear arrives
    assert_flag_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !flag_clr) |=> alarm_flag);

    // irq only rises when enabled at the matching edge
    assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(irq_en) && $past(tick_done)));

    // No second irq edge from a match while the flag stays set
    assert_no_reraise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (!$past(alarm_flag) || $past(flag_clr)));

    // The event follows a strobe and the flag is set with it (match wins, R9)
    assert_evt_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |-> ($past(tick_done) && alarm_flag));

    // irq never stands without the flag
    assert_irq_with_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> alarm_flag);

    // Disabling the interrupt drops irq at the next edge
    assert_irq_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq);

endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_done  (tick_done),
    .irq_en     (irq_en),
    .flag_clr   (flag_clr),
    .alarm_flag (alarm_flag),
    .alarm_evt  (alarm_evt),
    .irq        (irq)
);

// File: tb/rtc_alarm_match_test.sv
`timescale 1ns/1ps
// Directed bench for rtc_alarm_match: one task per scenario.
module rtc_alarm_match_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] cur_time = '0;
    logic        tick_done = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        irq_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic        alarm_flag;
    logic        alarm_evt;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int irq_rises = 0;

    always #2.5 clk = ~clk;

    rtc_alarm_match uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_time   (cur_time),
        .tick_done  (tick_done),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .irq_en     (irq_en),
        .flag_clr   (flag_clr),
        .alarm_flag (alarm_flag),
        .alarm_evt  (alarm_evt),
        .irq        (irq)
    );

    // Count rising edges of irq
    always @(posedge clk) begin
        if (rst_n && irq && !$past(irq)) irq_rises <= irq_rises + 1;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [39:0] tm(input logic [7:0] s, m, h, d, mo);
        return {mo, d, h, m, s};
    endfunction

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_alarm(input logic [7:0] s, m, h, d, mo);
        wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, d); wr(3'd4, mo);
    endtask

    // Strobe an update with the given time; returns after the result edge
    task automatic tick(input logic [39:0] t);
        @(negedge clk);
        cur_time = t; tick_done = 1'b1;
        @(negedge clk);
        tick_done = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "flag after reset", alarm_flag, 0);
        check("R1", "evt after reset", alarm_evt, 0);
        check("R1", "irq after reset", irq, 0);
        tick(tm(8'h00, 8'h00, 8'h00, 8'h00, 8'h00));
        check("R1", "alarm bytes zero: match all-zero time", alarm_flag, 1);
        clr();
        check("R5", "flag cleared", alarm_flag, 0);
    endtask

    task automatic t_exact();
        set_alarm(8'h30, 8'h45, 8'h12, 8'h15, 8'h06);
        tick(tm(8'h30, 8'h45, 8'h12, 8'h15, 8'h06));
        check("R3", "exact match flag", alarm_flag, 1);
        check("R8", "evt pulse", alarm_evt, 1);
        @(negedge clk);
        check("R8", "evt one cycle", alarm_evt, 0);
        repeat (4) @(negedge clk);
        check("R5", "flag held", alarm_flag, 1);
        clr();
        check("R5", "flag cleared", alarm_flag, 0);
    endtask

    task automatic t_no_tick();
        @(negedge clk);
        cur_time = tm(8'h30, 8'h45, 8'h12, 8'h15, 8'h06);
        repeat (5) @(negedge clk);
        check("R2", "no strobe no flag", alarm_flag, 0);
        check("R2", "no strobe no evt", alarm_evt, 0);
    endtask

    task automatic t_one_off();
        for (int f = 0; f < 5; f++) begin
            logic [39:0] t;
            t = tm(8'h30, 8'h45, 8'h12, 8'h15, 8'h06);
            t[f*8 +: 8] = t[f*8 +: 8] + 8'h01;
            tick(t);
            check("R3", $sformatf("field %0d differs", f), alarm_flag, 0);
        end
    endtask

    task automatic t_hourly();
        set_alarm(8'h30, 8'h45, 8'hC0, 8'hFF, 8'hD5);
        tick(tm(8'h30, 8'h45, 8'h07, 8'h01, 8'h11));
        check("R4", "hourly at 07", alarm_flag, 1);
        clr();
        tick(tm(8'h30, 8'h45, 8'h23, 8'h28, 8'h02));
        check("R4", "hourly at 23", alarm_flag, 1);
        clr();
        tick(tm(8'h30, 8'h46, 8'h23, 8'h28, 8'h02));
        check("R4", "hourly wrong minute", alarm_flag, 0);
    endtask

    task automatic t_daily();
        wr(3'd2, 8'h08);
        tick(tm(8'h30, 8'h45, 8'h08, 8'h19, 8'h03));
        check("R4", "daily at 08", alarm_flag, 1);
        clr();
        tick(tm(8'h30, 8'h45, 8'h09, 8'h19, 8'h03));
        check("R4", "daily wrong hour", alarm_flag, 0);
    endtask

    task automatic t_all_wild();
        set_alarm(8'hC0, 8'hC0, 8'hC0, 8'hC0, 8'hC0);
        tick(tm(8'h59, 8'h01, 8'h22, 8'h31, 8'h12));
        check("R4", "all wild tick 1", alarm_evt, 1);
        tick(tm(8'h00, 8'h02, 8'h22, 8'h31, 8'h12));
        check("R4", "all wild tick 2", alarm_evt, 1);
        clr();
    endtask

    task automatic t_partial_top();
        wr(3'd0, 8'h80);
        tick(tm(8'h00, 8'h00, 8'h00, 8'h01, 8'h01));
        check("R4", "top bits 10 not wild", alarm_flag, 0);
        tick(tm(8'h80, 8'h00, 8'h00, 8'h01, 8'h01));
        check("R4", "top bits 10 exact", alarm_flag, 1);
        clr();
    endtask

    task automatic t_irq();
        set_alarm(8'hC0, 8'hC0, 8'hC0, 8'hC0, 8'hC0);
        @(negedge clk); irq_en = 1'b1;
        tick(tm(8'h01, 8'h01, 8'h01, 8'h01, 8'h01));
        check("R6", "irq with enable", irq, 1);
        clr();
        check("R11", "irq cleared with flag", irq, 0);
        @(negedge clk); irq_en = 1'b0;
        tick(tm(8'h02, 8'h01, 8'h01, 8'h01, 8'h01));
        check("R6", "flag without enable", alarm_flag, 1);
        check("R6", "irq without enable", irq, 0);
        @(negedge clk); irq_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R6", "late enable no irq", irq, 0);
        clr();
    endtask

    task automatic t_no_second_edge();
        int base;
        base = irq_rises;
        tick(tm(8'h03, 8'h01, 8'h01, 8'h01, 8'h01));
        tick(tm(8'h04, 8'h01, 8'h01, 8'h01, 8'h01));
        check("R8", "evt on repeat match", alarm_evt, 1);
        check("R7", "irq still high", irq, 1);
        check("R7", "single irq edge", irq_rises - base, 1);
    endtask

    task automatic t_clear_vs_match();
        @(negedge clk);
        cur_time = tm(8'h05, 8'h01, 8'h01, 8'h01, 8'h01);
        tick_done = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        tick_done = 1'b0; flag_clr = 1'b0;
        check("R9", "match wins over clear", alarm_flag, 1);
        check("R9", "irq stays", irq, 1);
    endtask

    task automatic t_irq_disable();
        @(negedge clk); irq_en = 1'b0;
        @(negedge clk);
        check("R11", "irq drops on disable", irq, 0);
        check("R11", "flag unaffected", alarm_flag, 1);
        clr();
        irq_en = 1'b1;
    endtask

    task automatic t_write_sel();
        set_alarm(8'h10, 8'h20, 8'h03, 8'h04, 8'h05);
        wr(3'd5, 8'hC0); wr(3'd6, 8'hC0); wr(3'd7, 8'hC0);
        tick(tm(8'h10, 8'h20, 8'h03, 8'h04, 8'h05));
        check("R10", "bad index writes ignored: match", alarm_flag, 1);
        clr();
        tick(tm(8'h11, 8'h20, 8'h03, 8'h04, 8'h05));
        check("R10", "bad index writes ignored: no wildcard", alarm_flag, 0);
        // write in one cycle, strobe in the next
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h11;
        @(negedge clk);
        wr_en = 1'b0;
        cur_time = tm(8'h11, 8'h20, 8'h03, 8'h04, 8'h05); tick_done = 1'b1;
        @(negedge clk);
        tick_done = 1'b0;
        check("R10", "new byte used next cycle", alarm_flag, 1);
        clr();
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exact();
        t_no_tick();
        t_one_off();
        t_hourly();
        t_daily();
        t_all_wild();
        t_partial_top();
        t_irq();
        t_no_second_edge();
        t_clear_vs_match();
        t_irq_disable();
        t_write_sel();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule